// File: doc/BRIEF.md
# DMA Channel Address and Count Unit

This block keeps the address and count state of a single DMA channel. It holds two 22-bit addresses, called A and B, and a 16-bit operation count. Each of the three has a base copy and a current copy. Each address is split into an offset word and a segment/tag word. The tag word carries the upper address bits, a bus-choice flag, an I/O-page flag and a count-method field. The count-method field decides how that address moves from one datum to the next.

A control word sets two things. A flip flag decides whether A or B drives the source outputs, and the other address drives the destination outputs. A byte-mode flag picks a step size of 1 in byte mode or 2 in word mode. The transfer engine pulses `step` once for each datum it moves. On that pulse each current address moves by its own count method and the current count drops by one. A terminal-count flag shows when the count reaches zero. A `reload` pulse restarts the transfer by copying every base register into its current register. The bus cycles themselves are handled outside this block.

Registers are reached through a 4-bit select. The select codes are: 0 current A offset, 1 current A tag, 2 base A offset, 3 base A tag, 4 current B offset, 5 current B tag, 6 base B offset, 7 base B tag, 8 current count, 9 base count and 10 control. In the control word, bit 0 is the flip flag and bit 1 is byte mode. Any other select code reads as zero and ignores writes.

Top module: `xfer_addr_unit`

## Requirements
- R1: After reset every register reads zero and `term_cnt` is 0. This makes A the source and B the destination, in word mode.
- R2: A tag word holds bit 15 as the remote-bus flag, bit 14 as the I/O-page flag, bits 13:8 as address bits 21:16 and bits 4:3 as the count method. Bits 7:5 and 2:0 read back as zero whatever was written.
- R3: An offset word holds address bits 15:0 and reads back exactly as written.
- R4: With the flip flag (control bit 0) at 0, A drives `src_*` and B drives `dst_*`. With the flag at 1 the two are swapped.
- R5: Count method 00 adds the step size on each `step`. A carry out of the offset passes into bits 21:16, and the address wraps modulo 2^22.
- R6: Count method 01 subtracts the step size on each `step`. A borrow passes into bits 21:16, and the address wraps modulo 2^22.
- R7: Count methods 10 and 11 leave the address unchanged on `step`.
- R8: The step size is 2 when control bit 1 is 0 (word mode) and 1 when it is 1 (byte mode).
- R9: Each `step` lowers the current count by one. A count of zero counts as 65536, so a step from 0 gives 0xFFFF.
- R10: `term_cnt` rises in the cycle after a `step` that takes the count from 1 to 0. It stays high until the current count is written or a `reload` occurs.
- R11: Base registers change only when written. A `reload` copies base A, base B and the base count into their current registers and clears `term_cnt`.
- R12: A register write in the same cycle as a `step` or `reload` wins for the register being written. The other registers still step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select code |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| step | input | 1 | One datum moved: step the addresses and the count |
| reload | input | 1 | Copy the base registers into the current registers |
| src_addr | output | 22 | Current source address |
| src_remote | output | 1 | Source is on the remote bus |
| src_io | output | 1 | Source is an I/O-page reference |
| dst_addr | output | 22 | Current destination address |
| dst_remote | output | 1 | Destination is on the remote bus |
| dst_io | output | 1 | Destination is an I/O-page reference |
| term_cnt | output | 1 | Terminal count reached |

## Verification
A wrong current address reaches `src_addr` or `dst_addr` one cycle after the `step` or `reload` that caused it. From then on the error stays, because every later step builds on the bad value. A base register corrupted by a step does not show at once. It shows as a wrong current value on the next `reload`, or when the base register is read directly. A count fault shows in `term_cnt` in the cycle after the 1-to-0 step, either firing too early or too late or not firing at all. Carry and borrow errors show only when the offset crosses a 64K boundary or the address wraps at the ends of the 22-bit range.

// File: rtl/xau_pkg.sv
package xau_pkg;
  localparam int ADDR_W = 22;
  localparam int OFF_W  = 16;
  localparam int HI_W   = ADDR_W - OFF_W;
  localparam int WORD_W = 16;
  localparam int SEL_W  = 4;

  typedef enum logic [1:0] {
    MTH_INC  = 2'b00,
    MTH_DEC  = 2'b01,
    MTH_HLD0 = 2'b10,
    MTH_HLD1 = 2'b11
  } method_e;

  typedef struct packed {
    logic            remote;
    logic            io;
    logic [HI_W-1:0] hi;
    method_e         mth;
  } tag_t;

  // word layout: 15 remote, 14 io, 13:8 hi, 4:3 method, rest zero
  function automatic tag_t tag_unpack(input logic [WORD_W-1:0] w);
    tag_t t;
    t.remote = w[15];
    t.io     = w[14];
    t.hi     = w[13:8];
    t.mth    = method_e'(w[4:3]);
    return t;
  endfunction

  function automatic logic [WORD_W-1:0] tag_pack(input tag_t t);
    return {t.remote, t.io, t.hi, 3'b000, t.mth, 3'b000};
  endfunction

  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a,
                                                  input method_e m,
                                                  input logic byte_mode);
    logic [ADDR_W-1:0] delta;
    delta = byte_mode ? ADDR_W'(1) : ADDR_W'(2);
    case (m)
      MTH_INC: return a + delta;
      MTH_DEC: return a - delta;
      default: return a;
    endcase
  endfunction
endpackage

// File: rtl/xau_addr_slot.sv
module xau_addr_slot
  import xau_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_cur_off,
  input  logic                 wr_cur_tag,
  input  logic                 wr_base_off,
  input  logic                 wr_base_tag,
  input  logic [WORD_W-1:0]    wdata,
  input  logic                 step,
  input  logic                 reload,
  input  logic                 byte_mode,
  output logic [ADDR_W-1:0]    cur_addr,
  output logic                 cur_remote,
  output logic                 cur_io,
  output logic [WORD_W-1:0]    cur_off_word,
  output logic [WORD_W-1:0]    cur_tag_word,
  output logic [WORD_W-1:0]    base_off_word,
  output logic [WORD_W-1:0]    base_tag_word
);
  tag_t             cur_tag, base_tag;
  logic [OFF_W-1:0] cur_off, base_off;
  logic [ADDR_W-1:0] addr_stepped;
  logic             step_go;
  logic             cur_wr_any;
  logic             base_wr_any;

  assign step_go     = step & ~reload;
  assign cur_wr_any  = wr_cur_off | wr_cur_tag;
  assign base_wr_any = wr_base_off | wr_base_tag;
  assign addr_stepped = addr_next({cur_tag.hi, cur_off}, cur_tag.mth, byte_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_off <= '0;
      base_tag <= '0;
    end else begin
      if (wr_base_off) base_off <= wdata[OFF_W-1:0];
      if (wr_base_tag) base_tag <= tag_unpack(wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_off <= '0;
    end else if (wr_cur_off) begin
      cur_off <= wdata[OFF_W-1:0];
    end else if (reload) begin
      cur_off <= base_off;
    end else if (step_go) begin
      cur_off <= addr_stepped[OFF_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_tag <= '0;
    end else if (wr_cur_tag) begin
      cur_tag <= tag_unpack(wdata);
    end else if (reload) begin
      cur_tag <= base_tag;
    end else if (step_go) begin
      cur_tag.hi <= addr_stepped[ADDR_W-1:OFF_W];
    end
  end

  assign cur_addr      = {cur_tag.hi, cur_off};
  assign cur_remote    = cur_tag.remote;
  assign cur_io        = cur_tag.io;
  assign cur_off_word  = WORD_W'(cur_off);
  assign cur_tag_word  = tag_pack(cur_tag);
  assign base_off_word = WORD_W'(base_off);
  assign base_tag_word = tag_pack(base_tag);

  // R11
  base_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !base_wr_any |=> ($stable(base_off) && $stable(base_tag)));

  // R7
  hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && !cur_wr_any && cur_tag.mth[1]) |=> $stable(cur_addr));

  // R11
  reload_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !cur_wr_any && !base_wr_any) |=>
      (cur_off == $past(base_off) && cur_tag == $past(base_tag)));
endmodule

// File: rtl/xau_counter.sv
module xau_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cur,
  input  logic             wr_base,
  input  logic [CNT_W-1:0] wdata,
  input  logic             step,
  input  logic             reload,
  output logic [CNT_W-1:0] cur_cnt,
  output logic [CNT_W-1:0] base_cnt,
  output logic             tc
);
  logic step_go;
  logic last_datum;

  assign step_go    = step & ~reload;
  assign last_datum = (cur_cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_cnt <= '0;
    end else if (wr_base) begin
      base_cnt <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_cnt <= '0;
      tc      <= 1'b0;
    end else if (wr_cur) begin
      cur_cnt <= wdata;
      tc      <= 1'b0;
    end else if (reload) begin
      cur_cnt <= base_cnt;
      tc      <= 1'b0;
    end else if (step_go) begin
      cur_cnt <= cur_cnt - CNT_W'(1);
      if (last_datum) tc <= 1'b1;
    end
  end

  // R10
  tc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc) |-> $past(step_go && !wr_cur && last_datum));

  // R9
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && !wr_cur) |=> (cur_cnt == $past(cur_cnt) - CNT_W'(1)));

  // R12
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cur |=> (cur_cnt == $past(wdata) && !tc));
endmodule

// File: rtl/xfer_addr_unit.sv
module xfer_addr_unit
  import xau_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [SEL_W-1:0]   reg_sel,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  input  logic               step,
  input  logic               reload,
  output logic [ADDR_W-1:0]  src_addr,
  output logic               src_remote,
  output logic               src_io,
  output logic [ADDR_W-1:0]  dst_addr,
  output logic               dst_remote,
  output logic               dst_io,
  output logic               term_cnt
);
  localparam int NSLOT = 2;
  localparam int SLOT_REGS = 4;
  localparam logic [SEL_W-1:0] SEL_CNT_CUR  = SEL_W'(NSLOT * SLOT_REGS);
  localparam logic [SEL_W-1:0] SEL_CNT_BASE = SEL_W'(NSLOT * SLOT_REGS + 1);
  localparam logic [SEL_W-1:0] SEL_CTRL     = SEL_W'(NSLOT * SLOT_REGS + 2);

  logic flip, byte_mode;
  logic [ADDR_W-1:0] s_addr   [NSLOT];
  logic              s_remote [NSLOT];
  logic              s_io     [NSLOT];
  logic [WORD_W-1:0] s_rd     [NSLOT][SLOT_REGS];
  logic [CNT_W-1:0]  cur_cnt, base_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flip      <= 1'b0;
      byte_mode <= 1'b0;
    end else if (reg_wr && reg_sel == SEL_CTRL) begin
      flip      <= reg_wdata[0];
      byte_mode <= reg_wdata[1];
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam logic [SEL_W-1:0] BASE_SEL = SEL_W'(g * SLOT_REGS);
    xau_addr_slot i_slot (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_cur_off    (reg_wr && reg_sel == BASE_SEL),
      .wr_cur_tag    (reg_wr && reg_sel == BASE_SEL + SEL_W'(1)),
      .wr_base_off   (reg_wr && reg_sel == BASE_SEL + SEL_W'(2)),
      .wr_base_tag   (reg_wr && reg_sel == BASE_SEL + SEL_W'(3)),
      .wdata         (reg_wdata),
      .step          (step),
      .reload        (reload),
      .byte_mode     (byte_mode),
      .cur_addr      (s_addr[g]),
      .cur_remote    (s_remote[g]),
      .cur_io        (s_io[g]),
      .cur_off_word  (s_rd[g][0]),
      .cur_tag_word  (s_rd[g][1]),
      .base_off_word (s_rd[g][2]),
      .base_tag_word (s_rd[g][3])
    );
  end

  xau_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_cur   (reg_wr && reg_sel == SEL_CNT_CUR),
    .wr_base  (reg_wr && reg_sel == SEL_CNT_BASE),
    .wdata    (reg_wdata[CNT_W-1:0]),
    .step     (step),
    .reload   (reload),
    .cur_cnt  (cur_cnt),
    .base_cnt (base_cnt),
    .tc       (term_cnt)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_sel < SEL_CNT_CUR)
      reg_rdata = s_rd[reg_sel[2]][reg_sel[1:0]];
    else if (reg_sel == SEL_CNT_CUR)
      reg_rdata = WORD_W'(cur_cnt);
    else if (reg_sel == SEL_CNT_BASE)
      reg_rdata = WORD_W'(base_cnt);
    else if (reg_sel == SEL_CTRL)
      reg_rdata = {{(WORD_W-2){1'b0}}, byte_mode, flip};
  end

  assign src_addr   = flip ? s_addr[1]   : s_addr[0];
  assign src_remote = flip ? s_remote[1] : s_remote[0];
  assign src_io     = flip ? s_io[1]     : s_io[0];
  assign dst_addr   = flip ? s_addr[0]   : s_addr[1];
  assign dst_remote = flip ? s_remote[0] : s_remote[1];
  assign dst_io     = flip ? s_io[0]     : s_io[1];

  // R4
  src_dst_differ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(flip) |-> (src_addr == $past(dst_addr) || !$stable(s_addr[0]) || !$stable(s_addr[1])));
endmodule

// File: tb/test_xfer_addr_unit.sv
module test_xfer_addr_unit;
  localparam int PERIOD = 10;
  localparam int NV = 42;
  // op codes
  localparam logic [2:0] OP_WR = 0, OP_STEP = 1, OP_RLD = 2, OP_CREG = 3,
                         OP_CSRC = 4, OP_CDST = 5, OP_CTC = 6, OP_WRSTEP = 7;
  // vector: {req[3:0], op[2:0], sel[3:0], data[15:0], exp[23:0]}; exp for addr = {remote, io, addr22}
  localparam logic [50:0] VEC [NV] = '{
    {4'd3,  OP_WR,    4'd0,  16'hFFFE, 24'h0},        // R3 A cur offset
    {4'd2,  OP_WR,    4'd1,  16'h81E7, 24'h0},        // R2 remote, hi 01, inc, junk bits
    {4'd2,  OP_CREG,  4'd1,  16'h0,    24'h008100},   // R2 junk bits read zero
    {4'd3,  OP_WR,    4'd4,  16'h0001, 24'h0},
    {4'd2,  OP_WR,    4'd5,  16'h4008, 24'h0},        // io, dec
    {4'd9,  OP_WR,    4'd8,  16'h0002, 24'h0},
    {4'd4,  OP_CSRC,  4'd0,  16'h0,    24'h81FFFE},   // R4 A is source
    {4'd4,  OP_CDST,  4'd0,  16'h0,    24'h400001},
    {4'd5,  OP_STEP,  4'd0,  16'h0,    24'h0},
    {4'd5,  OP_CSRC,  4'd0,  16'h0,    24'h820000},   // R5 carry into hi
    {4'd6,  OP_CDST,  4'd0,  16'h0,    24'h7FFFFF},   // R6 wrap below zero
    {4'd10, OP_CTC,   4'd0,  16'h0,    24'h0},
    {4'd9,  OP_CREG,  4'd8,  16'h0,    24'h000001},
    {4'd10, OP_STEP,  4'd0,  16'h0,    24'h0},
    {4'd10, OP_CTC,   4'd0,  16'h0,    24'h1},        // R10 1 -> 0
    {4'd9,  OP_CREG,  4'd8,  16'h0,    24'h000000},
    {4'd9,  OP_STEP,  4'd0,  16'h0,    24'h0},
    {4'd10, OP_CTC,   4'd0,  16'h0,    24'h1},        // R10 sticky
    {4'd9,  OP_CREG,  4'd8,  16'h0,    24'h00FFFF},   // R9 0 -> FFFF
    {4'd4,  OP_WR,    4'd10, 16'h0003, 24'h0},        // flip + byte
    {4'd4,  OP_CSRC,  4'd0,  16'h0,    24'h7FFFFB},   // R4 B is source
    {4'd4,  OP_CDST,  4'd0,  16'h0,    24'h820004},
    {4'd8,  OP_STEP,  4'd0,  16'h0,    24'h0},
    {4'd8,  OP_CSRC,  4'd0,  16'h0,    24'h7FFFFA},   // R8 byte dec
    {4'd8,  OP_CDST,  4'd0,  16'h0,    24'h820005},   // R8 byte inc
    {4'd11, OP_WR,    4'd2,  16'h1234, 24'h0},
    {4'd11, OP_WR,    4'd3,  16'h0010, 24'h0},        // base A hold, local
    {4'd11, OP_STEP,  4'd0,  16'h0,    24'h0},
    {4'd11, OP_CREG,  4'd2,  16'h0,    24'h001234},   // R11 base untouched
    {4'd11, OP_CREG,  4'd3,  16'h0,    24'h000010},
    {4'd11, OP_RLD,   4'd0,  16'h0,    24'h0},
    {4'd11, OP_CDST,  4'd0,  16'h0,    24'h001234},   // R11 reload A
    {4'd11, OP_CTC,   4'd0,  16'h0,    24'h0},        // R11 reload clears tc
    {4'd11, OP_CREG,  4'd8,  16'h0,    24'h000000},
    {4'd7,  OP_STEP,  4'd0,  16'h0,    24'h0},
    {4'd7,  OP_CDST,  4'd0,  16'h0,    24'h001234},   // R7 hold
    {4'd9,  OP_CREG,  4'd8,  16'h0,    24'h00FFFF},
    {4'd11, OP_CSRC,  4'd0,  16'h0,    24'h000001},   // B reloaded to 0 then +1
    {4'd12, OP_WRSTEP,4'd8,  16'h0005, 24'h0},
    {4'd12, OP_CREG,  4'd8,  16'h0,    24'h000005},   // R12 write wins
    {4'd12, OP_CSRC,  4'd0,  16'h0,    24'h000002},   // R12 others still step
    {4'd3,  OP_CREG,  4'd0,  16'h0,    24'h001234}    // R3 offset readback
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, step = 1'b0, reload = 1'b0;
  logic [3:0] reg_sel = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [21:0] src_addr, dst_addr;
  logic src_remote, src_io, dst_remote, dst_io, term_cnt;
  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  xfer_addr_unit i_xfer_addr_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .step(step), .reload(reload),
    .src_addr(src_addr), .src_remote(src_remote), .src_io(src_io),
    .dst_addr(dst_addr), .dst_remote(dst_remote), .dst_io(dst_io),
    .term_cnt(term_cnt)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic wr, input logic stp, input logic rld,
                       input logic [3:0] sel, input logic [15:0] d);
    reg_wr = wr; step = stp; reload = rld; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; step = 0; reload = 0;
  endtask

  task automatic read_chk(input string req, input logic [3:0] sel, input logic [15:0] exp);
    reg_sel = sel;
    #1;
    check(req, {8'h0, reg_rdata}, {8'h0, exp});
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    read_chk("R1", 4'd10, 16'h0);
    read_chk("R1", 4'd8, 16'h0);
    read_chk("R1", 4'd1, 16'h0);
    check("R1", {23'h0, term_cnt}, 24'h0);
    check("R1", {src_remote, src_io, src_addr}, 24'h0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  rq;
      logic [2:0]  op;
      logic [3:0]  sl;
      logic [15:0] dt;
      logic [23:0] ex;
      string tag;
      {rq, op, sl, dt, ex} = VEC[i];
      tag = $sformatf("R%0d vec%0d", rq, i);
      case (op)
        OP_WR:     pulse(1, 0, 0, sl, dt);
        OP_STEP:   pulse(0, 1, 0, sl, dt);
        OP_RLD:    pulse(0, 0, 1, sl, dt);
        OP_WRSTEP: pulse(1, 1, 0, sl, dt);
        OP_CREG:   read_chk(tag, sl, ex[15:0]);
        OP_CSRC:   begin #1; check(tag, {src_remote, src_io, src_addr}, ex); end
        OP_CDST:   begin #1; check(tag, {dst_remote, dst_io, dst_addr}, ex); end
        default:   begin #1; check(tag, {23'h0, term_cnt}, ex); end
      endcase
    end

    // R10 write of current count clears tc
    pulse(1, 0, 0, 4'd8, 16'h0001);
    pulse(0, 1, 0, 4'd0, 16'h0);
    #1 check("R10", {23'h0, term_cnt}, 24'h1);
    pulse(1, 0, 0, 4'd8, 16'h0003);
    #1 check("R10", {23'h0, term_cnt}, 24'h0);
    // R12 write beats reload on that register
    pulse(1, 0, 1, 4'd8, 16'h0007);
    read_chk("R12", 4'd8, 16'h0007);
    // R5 wrap at top of 22-bit range, word mode, no flip
    pulse(1, 0, 0, 4'd10, 16'h0000);
    pulse(1, 0, 0, 4'd0, 16'hFFFF);
    pulse(1, 0, 0, 4'd1, 16'h3F00);
    pulse(0, 1, 0, 4'd0, 16'h0);
    #1 check("R5", {src_remote, src_io, src_addr}, 24'h000001);
    read_chk("R5", 4'd1, 16'h0000);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule